// File: doc/BRIEF.md
# Page-Buffered Write Load Controller

This block sits at the write side of a byte-wide nonvolatile memory model. It watches three active-low bus strobes (chip select, output enable, write strobe) and turns each qualified strobe pulse into one byte load. The address is taken when the pulse begins and the data when it ends. Loaded bytes go into a 64-entry page buffer that tracks which entries were filled. Each new byte restarts a load window. When the window runs out with no new byte, the controller runs a self-timed program cycle. During that cycle it drives a synchronous write port into a behavioural array, one cycle per filled buffer entry.

A load whose bytes do not all share one page is dropped when its window expires, and the array is not touched. Loads are refused while the supply-good input is low, and for a settling delay after it rises. Strobes that arrive during a program cycle have no effect. The strobe inputs are treated as already synchronous to `clk`. All durations are parameters given in clock cycles.

Top module: `page_load_ctrl`

## Requirements
- R1: A byte load happens only for a strobe pulse during which `ce_n`=0, `we_n`=0 and `oe_n`=1 all hold together; a pulse with `ce_n` high or `oe_n` low starts no load.
- R2: The address is sampled in the first cycle of the pulse and the data in its last active cycle; later address changes and earlier data values do not matter.
- R3: Address bits [5:0] pick the byte within a 64-byte page and bits [14:6] pick the page; each program write goes to `{page, byte}` and keeps the same page bits for the whole program cycle.
- R4: `load_timer_run` is high for exactly `WIN_CLKS` cycles after the end of the most recent accepted pulse, and every further accepted byte restarts that count.
- R5: When the window expires on a valid load, `busy` rises in the next cycle and stays high for exactly `PROG_CLKS` cycles; `mem_we` is only ever high while `busy` is high.
- R6: If any byte of a load carries page bits that differ from the first byte, the window expires with no program cycle and the array is unchanged.
- R7: Only buffer entries loaded in the current load are written (the last value wins for a repeated byte); every other array byte keeps its old value.
- R8: No load starts while `pwr_good` is low, or during the first `PU_CLKS` cycles after it rises.
- R9: Strobe pulses during a program cycle start no load and do not change the data being programmed.
- R10: After reset `busy`, `load_timer_run` and `mem_we` are 0 and `last_addr` is 0.
- R11: `last_addr` shows the address of the most recently accepted byte, including a byte that strays off the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 15 | Byte address from the bus |
| din | input | 8 | Write data from the bus |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low (high is needed for a write) |
| we_n | input | 1 | Write strobe, active low |
| pwr_good | input | 1 | Supply is above the write threshold |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 15 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |
| load_timer_run | output | 1 | Byte-load window is running |
| last_addr | output | 15 | Address of the last accepted byte |

## Verification
The properties assume that bus strobes are synchronous to `clk` and that `pwr_good` changes only between edges. The no-load-while-unpowered property also assumes nothing else can open a load in that cycle. The bench drives every input at the falling clock edge, so each strobe pulse covers whole cycles. It keeps the gap between bytes of one load well inside the window, so a restart never races an expiry. Each strobe pulse lasts at least two active cycles, so both the start-of-pulse address sample and the end-of-pulse data sample are exercised, with a different value on each bus at each point.

// File: rtl/pl_pkg.sv
package pl_pkg;
    typedef enum logic [1:0] {
        PL_IDLE = 2'd0,
        PL_LOAD = 2'd1,
        PL_PROG = 2'd2
    } pl_state_e;
endpackage

// File: rtl/pl_strobe_decode.sv
module pl_strobe_decode #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              byte_evt,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [DATA_W-1:0] byte_data
);
    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } dec_t;

    dec_t q, d;
    logic act_now;

    always_comb begin
        act_now = !ce_n && !we_n && oe_n;
        d       = q;
        d.act   = act_now;
        if (act_now && !q.act) d.addr = addr;
        if (act_now)           d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_evt  = q.act && !act_now;
    assign byte_addr = q.addr;
    assign byte_data = q.data;
endmodule

// File: rtl/pl_page_buffer.sv
module pl_page_buffer #(
    parameter int DATA_W = 8,
    parameter int OFFS_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [OFFS_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFFS_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int SLOTS = 1 << OFFS_W;

    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0] data;
        logic [SLOTS-1:0]             vld;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (clr) d.vld = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (wr && wr_idx == OFFS_W'(i)) begin
                d.data[i] = wr_data;
                d.vld[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data  = q.data[rd_idx];
    assign rd_valid = q.vld[rd_idx];
endmodule

// File: rtl/pl_load_seq.sv
module pl_load_seq
    import pl_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int OFFS_W    = 6,
    parameter int WIN_CLKS  = 15000,
    parameter int PROG_CLKS = 500000,
    parameter int PU_CLKS   = 500000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     byte_evt,
    input  logic [ADDR_W-1:0]        byte_addr,
    input  logic                     pwr_good,
    output logic                     buf_clr,
    output logic                     buf_wr,
    output logic                     busy,
    output logic                     timer_run,
    output logic [ADDR_W-1:0]        last_addr,
    output logic                     prog_slot,
    output logic [OFFS_W-1:0]        prog_idx,
    output logic [ADDR_W-OFFS_W-1:0] prog_page
);
    localparam int PAGE_W = ADDR_W - OFFS_W;
    localparam int SLOTS  = 1 << OFFS_W;
    localparam int TMR_W  = $clog2(WIN_CLKS + 1);
    localparam int PC_W   = $clog2(PROG_CLKS + 1);
    localparam int PU_W   = $clog2(PU_CLKS + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WIN_CLKS - 1);
    localparam logic [PC_W-1:0]  PC_LAST  = PC_W'(PROG_CLKS - 1);
    localparam logic [PC_W-1:0]  PC_SLOTS = PC_W'(SLOTS);
    localparam logic [PU_W-1:0]  PU_DONE  = PU_W'(PU_CLKS);

    typedef struct packed {
        pl_state_e         st;
        logic [PAGE_W-1:0] page;
        logic              bad;
        logic [TMR_W-1:0]  tmr;
        logic [PC_W-1:0]   pcnt;
        logic [PU_W-1:0]   pu;
        logic [ADDR_W-1:0] last;
    } seq_t;

    seq_t q, d;
    logic pwr_ok, accept;
    logic [PAGE_W-1:0] evt_page;

    always_comb begin
        d        = q;
        buf_clr  = 1'b0;
        buf_wr   = 1'b0;
        evt_page = byte_addr[ADDR_W-1:OFFS_W];
        pwr_ok   = pwr_good && (q.pu == PU_DONE);
        accept   = byte_evt && pwr_ok && (q.st != PL_PROG);

        if (!pwr_good)          d.pu = '0;
        else if (q.pu != PU_DONE) d.pu = q.pu + 1'b1;

        unique case (q.st)
            PL_IDLE: begin
                if (accept) begin
                    buf_clr = 1'b1;
                    buf_wr  = 1'b1;
                    d.page  = evt_page;
                    d.bad   = 1'b0;
                    d.tmr   = '0;
                    d.st    = PL_LOAD;
                end
            end
            PL_LOAD: begin
                if (accept) begin
                    buf_wr = 1'b1;
                    d.tmr  = '0;
                    if (evt_page != q.page) d.bad = 1'b1;
                end else if (q.tmr == TMR_LAST) begin
                    d.pcnt = '0;
                    d.st   = q.bad ? PL_IDLE : PL_PROG;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            PL_PROG: begin
                if (q.pcnt == PC_LAST) d.st = PL_IDLE;
                else                   d.pcnt = q.pcnt + 1'b1;
            end
            default: d.st = PL_IDLE;
        endcase

        if (accept) d.last = byte_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= PL_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st == PL_PROG);
    assign timer_run = (q.st == PL_LOAD);
    assign last_addr = q.last;
    assign prog_slot = busy && (q.pcnt < PC_SLOTS);
    assign prog_idx  = q.pcnt[OFFS_W-1:0];
    assign prog_page = q.page;
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int OFFS_W    = 6,
    parameter int WIN_CLKS  = 15000,
    parameter int PROG_CLKS = 500000,
    parameter int PU_CLKS   = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              pwr_good,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              load_timer_run,
    output logic [ADDR_W-1:0] last_addr
);
    localparam int PAGE_W = ADDR_W - OFFS_W;

    logic              byte_evt;
    logic [ADDR_W-1:0] byte_addr;
    logic [DATA_W-1:0] byte_data;
    logic              buf_clr, buf_wr, prog_slot, rd_valid;
    logic [OFFS_W-1:0] prog_idx;
    logic [PAGE_W-1:0] prog_page;
    logic [DATA_W-1:0] rd_data;

    pl_strobe_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .byte_evt(byte_evt),
        .byte_addr(byte_addr), .byte_data(byte_data)
    );

    pl_page_buffer #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr(buf_wr),
        .wr_idx(byte_addr[OFFS_W-1:0]), .wr_data(byte_data),
        .rd_idx(prog_idx), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    pl_load_seq #(
        .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .WIN_CLKS(WIN_CLKS),
        .PROG_CLKS(PROG_CLKS), .PU_CLKS(PU_CLKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .byte_evt(byte_evt), .byte_addr(byte_addr),
        .pwr_good(pwr_good), .buf_clr(buf_clr), .buf_wr(buf_wr),
        .busy(busy), .timer_run(load_timer_run), .last_addr(last_addr),
        .prog_slot(prog_slot), .prog_idx(prog_idx), .prog_page(prog_page)
    );

    assign mem_we    = prog_slot && rd_valid;
    assign mem_addr  = {prog_page, prog_idx};
    assign mem_wdata = rd_data;
endmodule

// File: rtl/pl_load_checks.sv
module pl_load_checks #(
    parameter int PAGE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              load_timer_run,
    input logic              mem_we,
    input logic              pwr_good,
    input logic [PAGE_W-1:0] mem_page
);
    a_r5_busy_excludes_load: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load_timer_run);

    a_r5_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    a_r5_busy_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(load_timer_run));

    a_r3_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_page));

    a_r8_no_load_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_good && !load_timer_run && !busy) |=> !load_timer_run);
endmodule

bind page_load_ctrl pl_load_checks #(.PAGE_W(ADDR_W - OFFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .load_timer_run(load_timer_run),
    .mem_we(mem_we), .pwr_good(pwr_good), .mem_page(mem_addr[ADDR_W-1:OFFS_W])
);

// File: tb/test_page_load_ctrl.sv
module test_page_load_ctrl;
    localparam int WIN  = 20;
    localparam int PROG = 100;
    localparam int PU   = 40;
    localparam int MSZ  = 32768;

    logic clk = 0;
    logic rst_n = 0;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic ce_n = 1, oe_n = 1, we_n = 1, pwr_good = 0;
    logic mem_we, busy, load_timer_run;
    logic [14:0] mem_addr, last_addr;
    logic [7:0]  mem_wdata;

    logic [7:0] arr [MSZ];
    logic [7:0] exp_arr [MSZ];
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    page_load_ctrl #(.WIN_CLKS(WIN), .PROG_CLKS(PROG), .PU_CLKS(PU)) i_page_load_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .pwr_good(pwr_good), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .load_timer_run(load_timer_run),
        .last_addr(last_addr)
    );

    always @(posedge clk) if (mem_we) arr[mem_addr] <= mem_wdata;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // one strobe pulse; ectl=1 makes chip select the late/early edge
    task automatic wr_byte(input logic [14:0] a, input logic [7:0] d, input bit ectl);
        @(negedge clk); addr = ~a; din = ~d; oe_n = 1;
        if (ectl) we_n = 0; else ce_n = 0;
        @(negedge clk); addr = a;
        if (ectl) ce_n = 0; else we_n = 0;
        @(negedge clk); addr = ~a; din = d;
        @(negedge clk); din = ~d;
        if (ectl) ce_n = 1; else we_n = 1;
        @(negedge clk); ce_n = 1; we_n = 1;
    endtask

    task automatic bad_pulse(input logic c, input logic o, input logic [14:0] a);
        @(negedge clk); addr = a; din = 8'h3C; ce_n = c; oe_n = o; we_n = 0;
        repeat (2) @(negedge clk);
        we_n = 1; ce_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    function automatic int arr_mismatch();
        int m = 0;
        for (int i = 0; i < MSZ; i++) if (arr[i] !== exp_arr[i]) m++;
        return m;
    endfunction

    // called right after the last byte task; measures window and program
    task automatic finish_load(input bit expect_prog, input string tag);
        int wc = 0, bc = 0;
        while (load_timer_run === 1'b1 && wc < 1000) begin wc++; @(negedge clk); end
        chk(wc == WIN, {tag, " R4 window length"}, wc, WIN);
        chk(busy === expect_prog, {tag, " R5/R6 busy after window"}, busy, expect_prog);
        while (busy === 1'b1 && bc < 1000) begin bc++; @(negedge clk); end
        if (expect_prog) chk(bc == PROG, {tag, " R5 program length"}, bc, PROG);
        repeat (2) @(negedge clk);
        chk(arr_mismatch() == 0, {tag, " R7 array contents"}, arr_mismatch(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [8:0] pg;
        void'($urandom(32'd1234));
        for (int i = 0; i < MSZ; i++) begin arr[i] = 8'hFF; exp_arr[i] = 8'hFF; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk(busy === 0 && load_timer_run === 0 && mem_we === 0, "R10 control outputs", {busy, load_timer_run, mem_we}, 0);
        chk(last_addr === 0, "R10 last_addr", last_addr, 0);

        // R8 power gating
        wr_byte(15'h0100, 8'h11, 0);
        chk(load_timer_run === 0, "R8 unpowered write", load_timer_run, 0);
        pwr_good = 1;
        wr_byte(15'h0101, 8'h22, 0);
        chk(load_timer_run === 0, "R8 write during settle delay", load_timer_run, 0);
        repeat (PU + 5) @(negedge clk);

        // R1 disqualified pulses
        bad_pulse(1'b0, 1'b0, 15'h0200);
        chk(load_timer_run === 0, "R1 output enable low", load_timer_run, 0);
        bad_pulse(1'b1, 1'b1, 15'h0201);
        chk(load_timer_run === 0, "R1 chip select high", load_timer_run, 0);

        // single byte, write-strobe controlled; R2 R3 R11
        wr_byte(15'h1234, 8'h5A, 0);
        exp_arr[15'h1234] = 8'h5A;
        chk(last_addr === 15'h1234, "R11 last_addr single", last_addr, 15'h1234);
        chk(load_timer_run === 1, "R4 window opens", load_timer_run, 1);
        finish_load(1, "single");
        chk(arr[15'h1234] === 8'h5A, "R2 data at pulse end", arr[15'h1234], 8'h5A);
        chk(arr[15'h1235] === 8'hFF, "R7 neighbour untouched", arr[15'h1235], 8'hFF);

        // multi byte, chip-select controlled, repeated byte, window restart
        wr_byte(15'h7FC0, 8'hA1, 1);
        wr_byte(15'h7FFF, 8'hB2, 1);
        wr_byte(15'h7FC0, 8'hC3, 0);
        exp_arr[15'h7FFF] = 8'hB2; exp_arr[15'h7FC0] = 8'hC3;
        finish_load(1, "multi");
        chk(arr[15'h7FC0] === 8'hC3, "R7 last value wins", arr[15'h7FC0], 8'hC3);
        chk(arr[15'h7FFF] === 8'hB2, "R3 top byte of page", arr[15'h7FFF], 8'hB2);

        // R6 stray byte discards the load
        wr_byte(15'h0840, 8'h01, 0);
        wr_byte(15'h0841, 8'h02, 0);
        wr_byte(15'h0880, 8'h03, 1);
        chk(last_addr === 15'h0880, "R11 last_addr stray", last_addr, 15'h0880);
        finish_load(0, "stray R6");

        // R9 strobe during program cycle
        wr_byte(15'h2005, 8'h77, 0);
        exp_arr[15'h2005] = 8'h77;
        while (load_timer_run === 1'b1) @(negedge clk);
        wr_byte(15'h2006, 8'h99, 0);
        chk(load_timer_run === 0, "R9 no load during busy", load_timer_run, 0);
        wr_byte(15'h4005, 8'h66, 1);
        chk(last_addr === 15'h2005, "R9 last_addr kept", last_addr, 15'h2005);
        while (busy === 1'b1) @(negedge clk);
        repeat (WIN + 5) @(negedge clk);
        chk(busy === 0 && load_timer_run === 0, "R9 nothing follows", {busy, load_timer_run}, 0);
        chk(arr_mismatch() == 0, "R9 array contents", arr_mismatch(), 0);

        // random loads
        for (int r = 0; r < 12; r++) begin
            int nb;
            bit stray;
            logic [14:0] a;
            logic [7:0]  d;
            logic [7:0]  tmp [MSZ];
            pg = 9'($urandom % 512);
            nb = 1 + int'($urandom % 6);
            stray = ($urandom % 4) == 0;
            for (int i = 0; i < MSZ; i++) tmp[i] = exp_arr[i];
            for (int b = 0; b < nb; b++) begin
                a = {pg, 6'($urandom % 64)};
                d = 8'($urandom);
                tmp[a] = d;
                wr_byte(a, d, 1'($urandom % 2));
                if (stray && b == 0)
                    wr_byte({pg ^ 9'(1 + $urandom % 511), 6'($urandom % 64)}, 8'($urandom), 0);
            end
            if (!stray) for (int i = 0; i < MSZ; i++) exp_arr[i] = tmp[i];
            finish_load(!stray, stray ? "random stray R6" : "random R3");
        end

        summary();
        $finish;
    end
endmodule